// File: doc/BRIEF.md
# Event-Triggered One-Shot Pulse Generator

This block makes a timed output pulse in hardware when a chosen event line rises. No processor is involved. Several event inputs pass through per-line synchronizers and rising-edge detectors. A source selector then picks one of them as the trigger. A dedicated up-counter is compared against a start value and an end value, and the compare results drive a registered output pin.

A small register-write port sets the control word, the two compare values and a clear strobe. The control word holds the output mode, the start policy, the auto-clear policy and the event source. The start policy is either armed or restart. In armed operation the counter sits at zero until an accepted event sets a status flag. In restart operation the counter runs freely and each event sends it back to zero. The status flag is visible on a pin.

Clearing the flag only by software gives a one-shot that waits to be re-armed. Letting the end-value match clear it too gives a one-shot that re-arms by itself. A continuous pulse train is also available.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: After reset `pulse_out` and `armed_out` are 0, and the output mode is off, so events have no effect until a control word is written.
- R2: A selected event line going high is seen after two synchronizer flops and an edge detector. In armed single-shot operation `pulse_out` is high after the third rising clock edge that follows the change. An event line held high for several cycles counts as one event.
- R3: In single-shot mode (control bits [1:0] = 1), `pulse_out` goes high on an accepted event and stays high for exactly the start compare value (address 1, must be at least 1) in clock cycles. It then stays low.
- R4: In dual-compare mode (control bits [1:0] = 2) with restart start policy (control bit 2 = 0), the counter wraps after reaching the end value E (address 2). The output is high for E−S cycles and low for S+1 cycles of every E+1 cycle period, where S is the start value.
- R5: In armed dual-compare mode (control bit 2 = 1) with auto-clear on (control bit 3 = 1), one event gives one pulse. The pulse rises S+1 cycles after the event is accepted and lasts E−S cycles. `armed_out` drops when the pulse ends, and a later event gives another pulse.
- R6: With auto-clear off, `armed_out` stays 1 after the pulse and further events are ignored. Writing 1 to bit 0 at address 3 clears the flag, and the next event is accepted.
- R7: An event that arrives while the flag is set does not restart or stretch a pulse in progress.
- R8: A clear write at address 3 in the same cycle as a trigger wins, leaving `armed_out` at 0 and `pulse_out` at 0.
- R9: Only the event line chosen by control bits [SRC_W+3:4] triggers; activity on the other lines is ignored.
- R10: In restart operation a selected event resets the running counter to zero. With S=5, the next rising edge of the output comes 6 cycles after the reset instead of where it would otherwise fall.
- R11: With mode field 0 (or the reserved code 3) the output is held low and the counter and flag are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 start compare, 2 end compare, 3 clear strobe |
| wr_data | input | CNT_W | Write data |
| evt_in | input | NUM_SRC | Asynchronous event inputs |
| pulse_out | output | 1 | Registered pulse output |
| armed_out | output | 1 | Trigger-status flag |

## Verification
Armed single-shot runs use random start values and random sources. They measure the pulse width and the latency from the event, which separates width errors from synchronizer-depth errors. Armed dual-compare runs with random value pairs give width E−S and delay S+1, so the two compare paths can be told apart.

A free-running dual-compare run measures high and low times, and then injects an event just after a falling edge. This shows whether the counter restarts. Directed cases aim a clear write and a trigger at the same edge, retrigger in mid-pulse, drive unselected sources, and use the disabled mode, so that priority and ignore rules show up at the pins.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_RSVD   = 2'd3
  } pmode_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CMPA  = 2'd1;
  localparam logic [1:0] ADDR_CMPB  = 2'd2;
  localparam logic [1:0] ADDR_CLEAR = 2'd3;
endpackage

// File: rtl/oneshot_regs.sv
module oneshot_regs
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output pmode_e           mode,
  output logic             trig_mode,
  output logic             auto_clr,
  output logic [SRC_W-1:0] src_sel,
  output logic [CNT_W-1:0] cmp_a,
  output logic [CNT_W-1:0] cmp_b,
  output logic             clr_sw
);
  // clear strobe acts at the edge where the write is taken
  assign clr_sw = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_OFF;
      trig_mode <= 1'b0;
      auto_clr  <= 1'b0;
      src_sel   <= '0;
      cmp_a     <= '0;
      cmp_b     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          mode      <= pmode_e'(wr_data[1:0]);
          trig_mode <= wr_data[2];
          auto_clr  <= wr_data[3];
          src_sel   <= wr_data[SRC_W+3:4];
        end
        ADDR_CMPA: cmp_a <= wr_data;
        ADDR_CMPB: cmp_b <= wr_data;
        default: ;
      endcase
    end
  end

  p_reset_off_r1: assert property (@(posedge clk) rst |=> (mode == MODE_OFF));
endmodule

// File: rtl/oneshot_evt_sync.sv
module oneshot_evt_sync #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic [SRC_W-1:0]   src_sel,
  output logic               trig
);
  logic [NUM_SRC-1:0] edge_v;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= evt_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign edge_v[i] = s2 & ~s3;

    // a held event line yields a single-cycle detection
    p_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
      edge_v[i] |=> !edge_v[i]);
  end

  assign trig = edge_v[src_sel];
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pmode_e           mode,
  input  logic             trig_mode,
  input  logic             auto_clr,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             trig,
  input  logic             clr_sw,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             accept,
  output logic             enabled
);
  logic end_hit;

  assign enabled = (mode == MODE_SINGLE) || (mode == MODE_DUAL);
  assign end_hit = (cnt == cmp_b);
  // software clear wins over a same-cycle trigger; a set flag blocks retrigger
  assign accept  = enabled && trig_mode && trig && !armed && !clr_sw;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (!enabled || clr_sw) begin
      armed <= 1'b0;
    end else if (trig_mode) begin
      if (armed && auto_clr && end_hit) armed <= 1'b0;
      else if (accept)                  armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enabled) begin
      cnt <= '0;
    end else if (trig_mode) begin
      if (!armed || clr_sw || (auto_clr && end_hit)) cnt <= '0;
      else if (mode == MODE_DUAL && end_hit)        cnt <= '0;
      else                                          cnt <= cnt + 1'b1;
    end else begin
      if (trig)                              cnt <= '0;
      else if (mode == MODE_DUAL && end_hit) cnt <= '0;
      else                                   cnt <= cnt + 1'b1;
    end
  end

  p_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    clr_sw |=> !armed);
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (trig_mode && !armed && !accept) |=> (cnt == '0));
  p_no_retrig_r7: assert property (@(posedge clk) disable iff (rst)
    (enabled && trig_mode && armed && !clr_sw && !end_hit) |=> armed);
  p_off_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> (cnt == '0 && !armed));
endmodule

// File: rtl/oneshot_outdrv.sv
module oneshot_outdrv
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pmode_e           mode,
  input  logic             enabled,
  input  logic             trig_mode,
  input  logic             armed,
  input  logic             accept,
  input  logic             trig,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic             pulse_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic run, start;
  logic [CNT_W-1:0] cnt_inc;

  assign run     = trig_mode ? armed : 1'b1;
  assign start   = trig_mode ? accept : trig;
  assign cnt_inc = cnt + ONE;

  always_ff @(posedge clk) begin
    if (rst || !enabled) begin
      pulse_out <= 1'b0;
    end else if (mode == MODE_SINGLE) begin
      if (start)                          pulse_out <= 1'b1;
      else if (run && cnt_inc == cmp_a)   pulse_out <= 1'b0;
    end else begin
      if (!run)                pulse_out <= 1'b0;
      else if (cnt == cmp_b)   pulse_out <= 1'b0;
      else if (cnt == cmp_a)   pulse_out <= 1'b1;
    end
  end

  p_off_low_r11: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> !pulse_out);
  p_single_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SINGLE && !pulse_out && !start) |=> !pulse_out);
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import oneshot_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               pulse_out,
  output logic               armed_out
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  pmode_e           mode;
  logic             trig_mode, auto_clr, clr_sw, trig;
  logic             armed, accept, enabled;
  logic [SRC_W-1:0] src_sel;
  logic [CNT_W-1:0] cmp_a, cmp_b, cnt;

  oneshot_regs #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .trig_mode(trig_mode), .auto_clr(auto_clr), .src_sel(src_sel),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .clr_sw(clr_sw)
  );

  oneshot_evt_sync #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_sync (
    .clk(clk), .rst(rst), .evt_in(evt_in), .src_sel(src_sel), .trig(trig)
  );

  oneshot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .mode(mode), .trig_mode(trig_mode),
    .auto_clr(auto_clr), .cmp_b(cmp_b), .trig(trig), .clr_sw(clr_sw),
    .cnt(cnt), .armed(armed), .accept(accept), .enabled(enabled)
  );

  oneshot_outdrv #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .mode(mode), .enabled(enabled),
    .trig_mode(trig_mode), .armed(armed), .accept(accept), .trig(trig),
    .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b), .pulse_out(pulse_out)
  );

  assign armed_out = armed;

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!pulse_out && !armed_out));
endmodule

// File: tb/sim_oneshot_pulse_gen.sv
`timescale 1ns/1ps
module sim_oneshot_pulse_gen;
  localparam int CNT_W = 16;
  localparam int NSRC  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [NSRC-1:0] evt_in = '0;
  logic pulse_out, armed_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oneshot_pulse_gen #(.CNT_W(CNT_W), .NUM_SRC(NSRC)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_in(evt_in), .pulse_out(pulse_out), .armed_out(armed_out)
  );

  function automatic logic [CNT_W-1:0] ctrl(int md, int armed_pol, int aclr, int src);
    return CNT_W'((src << 4) | (aclr << 3) | (armed_pol << 2) | md);
  endfunction
  function automatic int exp_ss_width(int s);            return s;     endfunction
  function automatic int exp_dual_width(int s, int e);   return e - s; endfunction
  function automatic int exp_dual_lat(int s);            return 4 + s; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive an event, return cycles to rise (-1 if none) and high width
  task automatic fire(int src, int retrig_at, int limit, output int lat, output int width);
    int k = 0;
    int w = 0;
    @(negedge clk);
    evt_in[src] = 1'b1;
    lat = -1;
    while (k < limit) begin
      @(negedge clk);
      k++;
      if (k == 4) evt_in[src] = 1'b0;
      if (pulse_out) begin
        lat = k;
        break;
      end
    end
    evt_in[src] = 1'b0;
    if (lat > 0) begin
      w = 0;
      while (pulse_out && w < 5000) begin
        @(negedge clk);
        w++;
        if (retrig_at > 0 && w == retrig_at)     evt_in[src] = 1'b1;
        if (retrig_at > 0 && w == retrig_at + 3) evt_in[src] = 1'b0;
      end
    end
    evt_in[src] = 1'b0;
    width = w;
  endtask

  task automatic wait_disarm();
    int g = 0;
    while (armed_out && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int lat, width, s, e, src, seed;
    seed = $urandom(32'd20240401);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pulse_out == 1'b0, "R1 out", pulse_out, 0);
    chk(armed_out == 1'b0, "R1 armed", armed_out, 0);
    wr(2'd1, 16'd3);
    fire(0, 0, 30, lat, width);
    chk(lat == -1, "R1 off after reset", lat, -1);

    // R11 explicit disabled and reserved codes
    wr(2'd0, ctrl(3, 1, 0, 0));
    fire(0, 0, 30, lat, width);
    chk(lat == -1 && armed_out == 1'b0, "R11 reserved mode", lat, -1);

    // R2/R3 random armed single-shot
    for (int i = 0; i < 6; i++) begin
      s = 1 + int'($urandom % 40);
      src = int'($urandom % NSRC);
      wr(2'd1, CNT_W'(s));
      wr(2'd2, CNT_W'(s + 5));
      wr(2'd0, ctrl(1, 1, 1, src));
      fire(src, 0, 50, lat, width);
      chk(lat == 3, "R2 latency", lat, 3);
      chk(width == exp_ss_width(s), "R3 width", width, exp_ss_width(s));
      repeat (3) @(negedge clk);
      chk(pulse_out == 1'b0, "R3 hold low", pulse_out, 0);
      wait_disarm();
    end

    // R5 random armed dual-compare with auto clear
    for (int i = 0; i < 4; i++) begin
      s = int'($urandom % 20);
      e = s + 1 + int'($urandom % 30);
      wr(2'd1, CNT_W'(s));
      wr(2'd2, CNT_W'(e));
      wr(2'd0, ctrl(2, 1, 1, 1));
      fire(1, 0, 80, lat, width);
      chk(lat == exp_dual_lat(s), "R5 delay", lat, exp_dual_lat(s));
      chk(width == exp_dual_width(s, e), "R5 width", width, exp_dual_width(s, e));
      chk(armed_out == 1'b0, "R5 auto clear", armed_out, 0);
    end
    fire(1, 0, 80, lat, width);
    chk(lat == exp_dual_lat(s), "R5 rearm", lat, exp_dual_lat(s));
    wait_disarm();

    // R6 software-only clear
    wr(2'd1, 16'd7);
    wr(2'd2, 16'd9);
    wr(2'd0, ctrl(1, 1, 0, 0));
    fire(0, 0, 30, lat, width);
    chk(width == 7, "R6 first pulse", width, 7);
    chk(armed_out == 1'b1, "R6 flag kept", armed_out, 1);
    fire(0, 0, 40, lat, width);
    chk(lat == -1, "R6 ignored while set", lat, -1);
    wr(2'd3, 16'd1);
    chk(armed_out == 1'b0, "R6 sw clear", armed_out, 0);
    fire(0, 0, 30, lat, width);
    chk(lat == 3 && width == 7, "R6 after clear", width, 7);
    wr(2'd3, 16'd1);

    // R7 retrigger mid-pulse
    wr(2'd1, 16'd30);
    wr(2'd2, 16'd35);
    wr(2'd0, ctrl(1, 1, 1, 0));
    fire(0, 10, 30, lat, width);
    chk(width == 30, "R7 no retrigger", width, 30);
    wait_disarm();

    // R8 clear and trigger on the same edge
    wr(2'd0, ctrl(1, 1, 0, 0));
    @(negedge clk); evt_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'd1;
    @(negedge clk); wr_en = 1'b0;
    chk(armed_out == 1'b0, "R8 clear wins armed", armed_out, 0);
    chk(pulse_out == 1'b0, "R8 clear wins out", pulse_out, 0);
    evt_in[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R9 unselected sources
    wr(2'd1, 16'd4);
    wr(2'd0, ctrl(1, 1, 1, 2));
    for (int j = 0; j < NSRC; j++) begin
      if (j != 2) begin
        fire(j, 0, 20, lat, width);
        chk(lat == -1, "R9 unselected", lat, -1);
      end
    end
    fire(2, 0, 20, lat, width);
    chk(lat == 3, "R9 selected", lat, 3);
    wait_disarm();

    // R4 free-running dual compare, R10 restart on event
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd20);
    wr(2'd0, ctrl(2, 0, 0, 3));
    begin
      int g = 0;
      int hi = 0;
      int lo = 0;
      while (!pulse_out && g < 100) begin @(negedge clk); g++; end
      while (pulse_out && g < 200)  begin @(negedge clk); g++; end
      while (!pulse_out && g < 300) begin @(negedge clk); g++; lo++; end
      while (pulse_out && g < 400)  begin @(negedge clk); g++; hi++; end
      chk(lo == 6, "R4 low time", lo, 6);
      chk(hi == 15, "R4 high time", hi, 15);
    end
    fire(3, 0, 40, lat, width);
    chk(lat == 9, "R10 restart", lat, 9);
    chk(width == 15, "R4 width after restart", width, 15);

    // R11 turning off forces low
    wr(2'd0, ctrl(0, 0, 0, 3));
    repeat (30) begin
      @(negedge clk);
      if (pulse_out) break;
    end
    chk(pulse_out == 1'b0, "R11 off low", pulse_out, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule